// File: doc/BRIEF.md
# Synchronous Serial Port with Continuous Transfer

This block is a clocked serial port with a data-out line, a data-in line and a shift clock. It exchanges data with a partner device in full duplex: each bit it sends on the falling edge of the shift clock is matched by a bit it samples on the rising edge. The shift clock either comes from an internal divider or, when the external mode is selected, from a pin driven by the partner. The direction in which bits leave and enter a byte is selectable.

Data lives in a small byte buffer shared with the host. A transfer reads a byte from the buffer, shifts it out while shifting the partner's bits into the same positions, and writes the result back to the same buffer entry. A single transfer moves one byte from entry 0. A continuous transfer moves a programmed number of bits, from 1 to 256, across consecutive entries. Between bytes the engine inserts a refill interval with the clock held high, and the host can hold the transfer at that point for as long as it likes.

The host starts a transfer with a one-cycle start pulse, watches the busy and done outputs, and reaches the buffer through a write port and a combinational read port.

Top module: `sio_stream`

## Requirements
- R1: After reset busy_o and done_o are 0, sck_o is 1 and sdo_o is 1.
- R2: With cont_i = 0 a start moves exactly 8 bits from buffer entry 0 and writes the received byte back to entry 0; nbits_m1_i has no effect in this mode.
- R3: With msb_first_i = 1 bit 7 of each byte is sent first and bit 0 last; with msb_first_i = 0 bit 0 is sent first and bit 7 last.
- R4: With the internal clock, consecutive rising edges of sck_o inside one byte are 2*(div_i+1) clock cycles apart, low and high phases each lasting div_i+1 cycles.
- R5: With cont_i = 1 a transfer makes exactly nbits_m1_i+1 rising edges and uses entries 0 up to ceil((nbits_m1_i+1)/8)-1. The bit received in transfer bit i is written to entry i/8 at position i%8 (bit 0 first) or 7-(i%8) (bit 7 first); untransferred positions of a partial last byte, and all unused entries, keep their contents.
- R6: sdo_o changes only together with a falling edge of sck_o, and sdi_i is sampled at the rising edge.
- R7: Between two bytes of a continuous transfer the spacing of the rising edges that enclose the boundary grows by GAP_CYC+2 clock cycles over the normal period.
- R8: When pause_i is high at the end of a byte that is not the last, no further clock edges occur and busy_o stays 1 until pause_i falls; the transfer then resumes and completes.
- R9: When the last programmed bit has been exchanged, done_o goes to 1 and busy_o to 0 in the same cycle; a start clears done_o.
- R10: While idle, sck_o rests at 1 and sdo_o holds the last bit sent.
- R11: With ext_clk_i = 1, bits move on the synchronized edges of sck_ext_i and sck_o stays at 1; the partner must leave at least SYNC_STAGES+3 clock cycles between the start pulse and its first falling edge.
- R12: A host write and the engine's write-back to the same buffer entry in the same cycle leave the engine's byte in the entry.
- R13: A start pulse while busy_o is 1 is ignored: the running transfer keeps its bit count and ends once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a transfer when idle |
| cont_i | input | 1 | 1 = continuous transfer of programmed length, 0 = single byte |
| msb_first_i | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| ext_clk_i | input | 1 | 1 = shift clock from sck_ext_i, 0 = internal divider |
| pause_i | input | 1 | Hold the transfer at the next byte boundary while high |
| div_i | input | DIV_W | Internal clock half-period minus one, in clock cycles |
| nbits_m1_i | input | CNT_W | Continuous transfer length minus one |
| buf_we_i | input | 1 | Host buffer write enable |
| buf_waddr_i | input | AW | Host buffer write address |
| buf_wdata_i | input | DW | Host buffer write data |
| buf_raddr_i | input | AW | Host buffer read address |
| buf_rdata_o | output | DW | Host buffer read data (combinational) |
| sck_ext_i | input | 1 | External shift clock |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated shift clock |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer has completed |

## Verification
The engine's write-back of a finished byte and a host write to the buffer can land on the same entry in the same cycle. The bench provokes this in a single-byte transfer by waiting for the eighth rising shift-clock edge, then issuing a host write to entry 0 with a marker value on the following cycle, exactly when the engine stores its byte. It judges the outcome by reading entry 0 through the host port after completion and expecting the byte assembled from the partner's bits, not the marker.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_LOAD,
      ENG_SHIFT,
      ENG_STORE,
      ENG_HOLD,
      ENG_GAP
   } eng_state_t;

endpackage

// File: rtl/sio_clkgen.sv
`timescale 1ns/1ps
module sio_clkgen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             ext_sel_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             sck_ext_i,
   output logic             fall_o,
   output logic             rise_o,
   output logic             sck_int_o
);

   logic [DIV_W-1:0]       cnt_q;
   logic                   sck_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   wrap;
   logic                   int_fall, int_rise, ext_fall, ext_rise, sync_now;

   assign wrap     = active_i && (cnt_q == div_i);
   assign int_fall = wrap && sck_q;
   assign int_rise = wrap && !sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (!active_i) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= sck_ext_i;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_ext_i};
         end
      end
   endgenerate

   assign sync_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_now;
   end

   assign ext_fall = active_i && prev_q && !sync_now;
   assign ext_rise = active_i && !prev_q && sync_now;

   assign fall_o    = ext_sel_i ? ext_fall : int_fall;
   assign rise_o    = ext_sel_i ? ext_rise : int_rise;
   assign sck_int_o = sck_q;

endmodule

// File: rtl/sio_buffer.sv
`timescale 1ns/1ps
module sio_buffer #(
   parameter  int DW    = 8,
   parameter  int DEPTH = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          h_we_i,
   input  logic [AW-1:0] h_waddr_i,
   input  logic [DW-1:0] h_wdata_i,
   input  logic [AW-1:0] h_raddr_i,
   output logic [DW-1:0] h_rdata_o,
   input  logic          e_we_i,
   input  logic [AW-1:0] e_addr_i,
   input  logic [DW-1:0] e_wdata_i,
   output logic [DW-1:0] e_rdata_o
);

   logic [DW-1:0] mem_q [DEPTH];

   // Engine write is issued last so it prevails on an address clash.
   always_ff @(posedge clk) begin
      if (h_we_i) mem_q[h_waddr_i] <= h_wdata_i;
      if (e_we_i) mem_q[e_addr_i]  <= e_wdata_i;
   end

   assign h_rdata_o = mem_q[h_raddr_i];
   assign e_rdata_o = mem_q[e_addr_i];

endmodule

// File: rtl/sio_engine.sv
`timescale 1ns/1ps
module sio_engine
   import sio_pkg::*;
#(
   parameter  int DW      = 8,
   parameter  int AW      = 5,
   parameter  int CNT_W   = 8,
   parameter  int GAP_CYC = 2,
   localparam int BW      = $clog2(DW),
   localparam int GW      = $clog2(GAP_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic             msb_first_i,
   input  logic             pause_i,
   input  logic [CNT_W-1:0] nbits_m1_i,
   input  logic             fall_i,
   input  logic             rise_i,
   input  logic             sdi_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic [AW-1:0]    addr_o,
   output logic             wr_en_o,
   output logic [DW-1:0]    wr_data_o,
   output logic             active_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             sdo_o
);

   eng_state_t       state_q;
   logic [AW-1:0]    byte_q;
   logic [BW-1:0]    bit_q;
   logic [CNT_W-1:0] left_q;
   logic [DW-1:0]    tx_q, rx_q;
   logic [GW-1:0]    gap_q;
   logic             msb_q, fin_q, done_q, sdo_q;
   logic [BW-1:0]    pos;

   assign pos = msb_q ? (BW'(DW - 1) - bit_q) : bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         byte_q  <= '0;
         bit_q   <= '0;
         left_q  <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         gap_q   <= '0;
         msb_q   <= 1'b0;
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
         sdo_q   <= 1'b1;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (start_i) begin
                  left_q  <= cont_i ? nbits_m1_i : CNT_W'(DW - 1);
                  msb_q   <= msb_first_i;
                  byte_q  <= '0;
                  done_q  <= 1'b0;
                  state_q <= ENG_LOAD;
               end
            end
            ENG_LOAD: begin
               tx_q    <= rd_data_i;
               rx_q    <= rd_data_i;
               bit_q   <= '0;
               state_q <= ENG_SHIFT;
            end
            ENG_SHIFT: begin
               if (fall_i) sdo_q <= tx_q[pos];
               if (rise_i) begin
                  rx_q[pos] <= sdi_i;
                  bit_q     <= bit_q + 1'b1;
                  if (left_q != '0) left_q <= left_q - 1'b1;
                  if (left_q == '0 || bit_q == BW'(DW - 1)) begin
                     fin_q   <= (left_q == '0);
                     state_q <= ENG_STORE;
                  end
               end
            end
            ENG_STORE: begin
               if (fin_q) begin
                  done_q  <= 1'b1;
                  state_q <= ENG_IDLE;
               end else begin
                  byte_q  <= byte_q + 1'b1;
                  gap_q   <= '0;
                  state_q <= pause_i ? ENG_HOLD : ENG_GAP;
               end
            end
            ENG_HOLD: begin
               if (!pause_i) state_q <= ENG_GAP;
            end
            ENG_GAP: begin
               if (gap_q == GW'(GAP_CYC - 1)) state_q <= ENG_LOAD;
               else                           gap_q   <= gap_q + 1'b1;
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign addr_o    = byte_q;
   assign wr_en_o   = (state_q == ENG_STORE);
   assign wr_data_o = rx_q;
   assign active_o  = (state_q == ENG_SHIFT);
   assign busy_o    = (state_q != ENG_IDLE);
   assign done_o    = done_q;
   assign sdo_o     = sdo_q;

endmodule

// File: rtl/sio_stream.sv
`timescale 1ns/1ps
module sio_stream #(
   parameter  int DW          = 8,
   parameter  int DIV_W       = 8,
   parameter  int CNT_W       = 8,
   parameter  int BUF_DEPTH   = 32,
   parameter  int GAP_CYC     = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(BUF_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic             msb_first_i,
   input  logic             ext_clk_i,
   input  logic             pause_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [CNT_W-1:0] nbits_m1_i,
   input  logic             buf_we_i,
   input  logic [AW-1:0]    buf_waddr_i,
   input  logic [DW-1:0]    buf_wdata_i,
   input  logic [AW-1:0]    buf_raddr_i,
   output logic [DW-1:0]    buf_rdata_o,
   input  logic             sck_ext_i,
   input  logic             sdi_i,
   output logic             sck_o,
   output logic             sdo_o,
   output logic             busy_o,
   output logic             done_o
);

   generate
      if (BUF_DEPTH * DW < (1 << CNT_W)) begin : g_bad_depth
         $error("buffer too small for the longest transfer");
      end
      if ((1 << AW) != BUF_DEPTH) begin : g_bad_pow2
         $error("BUF_DEPTH must be a power of two");
      end
      if ((1 << $clog2(DW)) != DW) begin : g_bad_dw
         $error("DW must be a power of two");
      end
      if (GAP_CYC < 1 || SYNC_STAGES < 1) begin : g_bad_gap
         $error("GAP_CYC and SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic          fall, rise, active, sck_int, e_we;
   logic [AW-1:0] e_addr;
   logic [DW-1:0] e_wdata, e_rdata;

   sio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) clkgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .ext_sel_i (ext_clk_i),
      .div_i     (div_i),
      .sck_ext_i (sck_ext_i),
      .fall_o    (fall),
      .rise_o    (rise),
      .sck_int_o (sck_int)
   );

   sio_buffer #(.DW(DW), .DEPTH(BUF_DEPTH)) buffer_i (
      .clk       (clk),
      .h_we_i    (buf_we_i),
      .h_waddr_i (buf_waddr_i),
      .h_wdata_i (buf_wdata_i),
      .h_raddr_i (buf_raddr_i),
      .h_rdata_o (buf_rdata_o),
      .e_we_i    (e_we),
      .e_addr_i  (e_addr),
      .e_wdata_i (e_wdata),
      .e_rdata_o (e_rdata)
   );

   sio_engine #(.DW(DW), .AW(AW), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) engine_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .cont_i      (cont_i),
      .msb_first_i (msb_first_i),
      .pause_i     (pause_i),
      .nbits_m1_i  (nbits_m1_i),
      .fall_i      (fall),
      .rise_i      (rise),
      .sdi_i       (sdi_i),
      .rd_data_i   (e_rdata),
      .addr_o      (e_addr),
      .wr_en_o     (e_we),
      .wr_data_o   (e_wdata),
      .active_o    (active),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .sdo_o       (sdo_o)
   );

   assign sck_o = ext_clk_i ? 1'b1 : sck_int;

endmodule

// File: rtl/sio_stream_chk.sv
`timescale 1ns/1ps
module sio_stream_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic ext_clk_i,
   input logic sck_o,
   input logic sdo_o,
   input logic busy_o,
   input logic done_o
);

   p_idle_sck_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sck_o);

   p_sdo_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clk_i && !$stable(sdo_o)) |-> $fell(sck_o));

   p_ext_sck_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk_i |-> sck_o);

   p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (!busy_o && $past(busy_o)));

   p_start_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> !done_o);

   p_busy_from_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

bind sio_stream sio_stream_chk chk_i (.*);

// File: tb/sio_stream_tb_top.sv
`timescale 1ns/1ps
module sio_stream_tb_top;

   localparam int GAP_CYC = 2;
   localparam int NB      = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, cont_i = 1'b0, msb_first_i = 1'b0;
   logic       ext_clk_i = 1'b0, pause_i = 1'b0;
   logic [7:0] div_i = '0, nbits_m1_i = '0;
   logic       buf_we_i = 1'b0;
   logic [4:0] buf_waddr_i = '0, buf_raddr_i = '0;
   logic [7:0] buf_wdata_i = '0, buf_rdata_o;
   logic       sck_ext_i = 1'b1, sdi_i = 1'b0;
   logic       sck_o, sdo_o, busy_o, done_o;

   always #2 clk = ~clk;

   sio_stream dut_i (.*);

   int     tests = 0, fails = 0;
   logic   exp_q[$];
   int     edge_cnt = 0, slv_idx = 0, cur_div = 0;
   bit     armed = 0, ext_tb = 0, tmg = 0;
   longint last_t = 0;
   logic   slv_bits[256];
   logic [7:0] mem_exp[NB];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: scoreboard pop on every generated rising edge
   always @(posedge sck_o) begin
      if (armed && !ext_tb) begin
         #1;
         if (tmg && edge_cnt > 0) begin
            int sp;
            int want;
            sp   = int'(($time - last_t) / 4);
            want = 2 * (cur_div + 1) + ((edge_cnt % 8 == 0) ? GAP_CYC + 2 : 0);
            chk(sp == want, (edge_cnt % 8 == 0) ? "R7 byte gap spacing" : "R4 bit period", sp, want);
         end
         last_t = $time;
         if (exp_q.size() == 0) chk(1'b0, "R5 extra clock edge", edge_cnt + 1, edge_cnt);
         else begin
            logic e;
            e = exp_q.pop_front();
            chk(sdo_o === e, "R3 sent bit", int'(sdo_o), int'(e));
         end
         edge_cnt++;
      end
   end

   // Partner drives its bit after each falling edge
   always @(negedge sck_o) begin
      if (armed && !ext_tb) begin
         #1;
         if (slv_idx < 256) sdi_i = slv_bits[slv_idx];
         slv_idx++;
      end
   end

   task automatic host_wr(input int a, input logic [7:0] d);
      @(negedge clk);
      buf_we_i = 1'b1; buf_waddr_i = 5'(a); buf_wdata_i = d;
      @(negedge clk);
      buf_we_i = 1'b0;
   endtask

   // mode: 0 plain, 1 restart while busy, 2 pause, 3 buffer clash
   task automatic run_xfer(input int nfield, input bit cont, input bit msb, input int div,
                           input bit ext, input int seed, input bit tmg_i, input int mode);
      logic [7:0] tx[NB];
      int n, wt;
      logic last_bit;
      n = cont ? nfield + 1 : 8;
      for (int k = 0; k < NB; k++) begin
         tx[k] = 8'((k * 37) + (seed * 11) + 5);
         mem_exp[k] = tx[k];
         host_wr(k, tx[k]);
      end
      for (int i = 0; i < 256; i++) slv_bits[i] = logic'((((i * 13) + seed) >> 1) & 1);
      exp_q.delete();
      last_bit = 1'b0;
      for (int i = 0; i < n; i++) begin
         int k, p;
         k = i / 8;
         p = msb ? 7 - (i % 8) : (i % 8);
         exp_q.push_back(tx[k][p]);
         mem_exp[k][p] = slv_bits[i];
         last_bit = tx[k][p];
      end
      @(negedge clk);
      cont_i = cont; msb_first_i = msb; div_i = 8'(div); ext_clk_i = ext;
      nbits_m1_i = 8'(nfield); pause_i = (mode == 2);
      edge_cnt = 0; slv_idx = 0; ext_tb = ext; cur_div = div; tmg = tmg_i; armed = 1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0 && busy_o == 1'b1, "R9 start clears done, sets busy",
          int'({done_o, busy_o}), 1);
      if (ext) begin
         repeat (6) @(negedge clk);
         for (int i = 0; i < n; i++) begin
            logic e;
            sck_ext_i = 1'b0; sdi_i = slv_bits[i];
            repeat (12) @(negedge clk);
            e = exp_q.pop_front();
            chk(sdo_o === e, "R11 external clock sent bit", int'(sdo_o), int'(e));
            chk(sck_o == 1'b1, "R11 sck_o rests high", int'(sck_o), 1);
            edge_cnt++;
            sck_ext_i = 1'b1;
            repeat (12) @(negedge clk);
         end
      end else if (mode == 1) begin
         wait (edge_cnt >= 3);
         @(negedge clk); start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end else if (mode == 2) begin
         wait (edge_cnt == 8);
         repeat (60) @(negedge clk);
         chk(edge_cnt == 8 && busy_o && sck_o, "R8 held at byte boundary", edge_cnt, 8);
         pause_i = 1'b0;
      end else if (mode == 3) begin
         wait (edge_cnt == 8);
         @(negedge clk);
         buf_we_i = 1'b1; buf_waddr_i = 5'd0; buf_wdata_i = ~mem_exp[0];
         @(negedge clk);
         buf_we_i = 1'b0;
      end
      wt = 0;
      while (!done_o && wt < 20000) begin
         @(negedge clk);
         wt++;
      end
      chk(done_o == 1'b1 && busy_o == 1'b0, "R9 done and not busy at end", int'({done_o, busy_o}), 2);
      chk(edge_cnt == n, (mode == 1) ? "R13 restart ignored, bit count" : (cont ? "R5 bit count" : "R2 single bit count"),
          edge_cnt, n);
      chk(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
      repeat (20) @(negedge clk);
      armed = 0;
      chk(sck_o == 1'b1 && sdo_o == last_bit, "R10 idle lines", int'({sck_o, sdo_o}), int'({1'b1, last_bit}));
      for (int k = 0; k < NB; k++) begin
         @(negedge clk);
         buf_raddr_i = 5'(k);
         #1;
         chk(buf_rdata_o == mem_exp[k], (mode == 3 && k == 0) ? "R12 engine write wins" : "R5 R6 buffer byte",
             int'(buf_rdata_o), int'(mem_exp[k]));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset busy/done", int'({busy_o, done_o}), 0);
      chk(sck_o == 1'b1 && sdo_o == 1'b1, "R1 reset lines", int'({sck_o, sdo_o}), 3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_xfer(3,   1'b0, 1'b0, 0, 1'b0, 1, 1'b1, 0);  // R2: single, length field ignored
      run_xfer(0,   1'b0, 1'b1, 3, 1'b0, 2, 1'b1, 0);  // R3 msb first, R4 slower clock
      run_xfer(12,  1'b1, 1'b1, 1, 1'b0, 3, 1'b1, 0);  // R5 partial last byte
      run_xfer(255, 1'b1, 1'b0, 0, 1'b0, 4, 1'b1, 0);  // R5 full 256 bits, R7 gaps
      run_xfer(0,   1'b1, 1'b0, 2, 1'b0, 5, 1'b1, 0);  // R5 single bit
      run_xfer(19,  1'b1, 1'b0, 1, 1'b0, 6, 1'b1, 1);  // R13 start while busy
      run_xfer(15,  1'b1, 1'b1, 1, 1'b0, 7, 1'b0, 2);  // R8 pause
      run_xfer(7,   1'b0, 1'b0, 0, 1'b0, 8, 1'b1, 3);  // R12 buffer clash
      run_xfer(11,  1'b1, 1'b1, 0, 1'b1, 9, 1'b0, 0);  // R11 external clock
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule